// File: doc/BRIEF.md
# Dual-Port Hardware Semaphore Bank

This block holds a bank of hardware lock flags. Two independent ports share the bank, and software on each side uses it to claim a shared resource before touching it. A port requests a flag by writing 0 to it and releases the flag by writing 1. Reading a flag returns 0 only to the port that currently holds it. Every other reader sees 1.

A request that arrives while the other side holds the flag is not lost. It is remembered as pending. When the holder releases the flag, the token moves straight to the waiting port, so that port does not have to poll and retry. A port can withdraw its pending request by writing 1 before it is granted.

Each read is answered one clock later as a single-beat response marked by a valid strobe. There is no ready input and no back-pressure. The response is a snapshot of the flag, and the consumer must take it in the cycle it is presented. Writes and reads are accepted every cycle, so the block never stalls a port.

Top module: `hw_semaphore_bank`

## Requirements
- R1: The bank holds N_FLAGS (default 8) independent flags. The port index input selects one of them, and an operation on one flag leaves every other flag unchanged.
- R2: A port reaches the bank only in a cycle where its memory-enable input is low and its semaphore-select input is high. In any other cycle its write has no effect and its read produces no response.
- R3: A write carries one data bit: 0 requests the flag and 1 releases it. A read produces a response one cycle later, with rvalid high for exactly that cycle. The response repeats the flag's view on all DATA_W (default 9) bits: all zeros if the reading port holds the flag, all ones otherwise. The view is taken as the flag stood before any write in that same cycle.
- R4: Writing 0 to a free flag grants the token to the writer. The writer then reads 0 and the other port reads 1.
- R5: Writing 0 to a flag that the other port holds causes no visible change to either port's view, and the request is recorded as pending.
- R6: When the holder writes 1 while the other port has a pending request, the token passes to the other port, which then reads 0.
- R7: When the holder writes 1 and no request is pending, the flag becomes free and reads 1 on both ports.
- R8: After reset, every flag is free with no pending request, and both rvalid outputs are low.
- R9: If both ports write 0 to the same free flag in the same cycle, port 0 takes the token and the port 1 request stays pending.
- R10: A pending request is withdrawn when the requesting port writes 1 to that flag before it is granted. A later release by the holder then frees the flag.
- R11: Writing 1 to a free flag, or writing 0 to a flag the writer already holds, leaves the flag unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| p0_mem_en | input | 1 | Port 0 memory enable; must be low for bank access |
| p0_sem_sel | input | 1 | Port 0 semaphore select; must be high for bank access |
| p0_we | input | 1 | Port 0 write (1) or read (0) |
| p0_idx | input | IDX_W | Port 0 flag index |
| p0_wbit | input | 1 | Port 0 write bit: 0 requests, 1 releases |
| p0_rvalid | output | 1 | Port 0 read response valid, one cycle |
| p0_rdata | output | DATA_W | Port 0 read response, flag view replicated |
| p1_mem_en | input | 1 | Port 1 memory enable; must be low for bank access |
| p1_sem_sel | input | 1 | Port 1 semaphore select; must be high for bank access |
| p1_we | input | 1 | Port 1 write (1) or read (0) |
| p1_idx | input | IDX_W | Port 1 flag index |
| p1_wbit | input | 1 | Port 1 write bit: 0 requests, 1 releases |
| p1_rvalid | output | 1 | Port 1 read response valid, one cycle |
| p1_rdata | output | DATA_W | Port 1 read response, flag view replicated |

## Verification
The bench builds the bank with its default parameters: eight flags and a nine-bit read response. With these values the top index 7 is reachable, and the bench can confirm that all nine response bits carry the same value. The chosen values also let independent flags be held at the same time by different ports. The bench drives same-cycle collisions on one flag, hand-off through a pending request, withdrawal of a request, and gated accesses. Read responses are checked in order against expectations queued by the driver.

// File: rtl/sem_pkg.sv
package sem_pkg;
  typedef enum logic [1:0] {
    SEM_FREE    = 2'd0,
    SEM_HELD_P0 = 2'd1,
    SEM_HELD_P1 = 2'd2
  } sem_state_t;

  typedef struct packed {
    logic take;  // write of 0: request
    logic drop;  // write of 1: release or withdraw
  } sem_req_t;
endpackage

// File: rtl/sem_port_decode.sv
module sem_port_decode #(
  parameter int N_FLAGS = 8,
  parameter int IDX_W   = 3
) (
  input  logic               mem_en,
  input  logic               sem_sel,
  input  logic               we,
  input  logic [IDX_W-1:0]   idx,
  input  logic               wbit,
  output logic [N_FLAGS-1:0] take,
  output logic [N_FLAGS-1:0] drop,
  output logic               rd_en
);
  logic acc;
  assign acc   = sem_sel && !mem_en;
  assign rd_en = acc && !we;

  for (genvar g = 0; g < N_FLAGS; g++) begin : g_dec
    logic hit;
    assign hit     = acc && we && (idx == IDX_W'(g));
    assign take[g] = hit && !wbit;
    assign drop[g] = hit && wbit;
  end
endmodule

// File: rtl/sem_flag_fsm.sv
module sem_flag_fsm
  import sem_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  sem_req_t r0,
  input  sem_req_t r1,
  output logic     held0,
  output logic     held1,
  output logic     waiting
);
  sem_state_t st_q, st_d;
  logic       wt_q, wt_d;

  always_comb begin
    st_d = st_q;
    wt_d = wt_q;
    unique case (st_q)
      SEM_FREE: begin
        if (r0.take) begin
          st_d = SEM_HELD_P0;
          wt_d = r1.take;           // port 0 wins a tie
        end else if (r1.take) begin
          st_d = SEM_HELD_P1;
          wt_d = 1'b0;
        end
      end
      SEM_HELD_P0: begin
        if (r0.drop) begin
          st_d = (r1.take || (wt_q && !r1.drop)) ? SEM_HELD_P1 : SEM_FREE;
          wt_d = 1'b0;
        end else if (r1.take) begin
          wt_d = 1'b1;
        end else if (r1.drop) begin
          wt_d = 1'b0;
        end
      end
      SEM_HELD_P1: begin
        if (r1.drop) begin
          st_d = (r0.take || (wt_q && !r0.drop)) ? SEM_HELD_P0 : SEM_FREE;
          wt_d = 1'b0;
        end else if (r0.take) begin
          wt_d = 1'b1;
        end else if (r0.drop) begin
          wt_d = 1'b0;
        end
      end
      default: begin
        st_d = SEM_FREE;
        wt_d = 1'b0;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= SEM_FREE;
      wt_q <= 1'b0;
    end else begin
      st_q <= st_d;
      wt_q <= wt_d;
    end
  end

  assign held0   = (st_q == SEM_HELD_P0);
  assign held1   = (st_q == SEM_HELD_P1);
  assign waiting = wt_q;
endmodule

// File: rtl/sem_read_port.sv
module sem_read_port #(
  parameter int N_FLAGS = 8,
  parameter int IDX_W   = 3,
  parameter int DATA_W  = 9
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               rd_en,
  input  logic [IDX_W-1:0]   idx,
  input  logic [N_FLAGS-1:0] mine,
  output logic               rvalid,
  output logic [DATA_W-1:0]  rdata
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rvalid <= 1'b0;
      rdata  <= '0;
    end else begin
      rvalid <= rd_en;
      if (rd_en) rdata <= {DATA_W{!mine[idx]}};
    end
  end
endmodule

// File: rtl/hw_semaphore_bank.sv
module hw_semaphore_bank
  import sem_pkg::*;
#(
  parameter int N_FLAGS = 8,
  parameter int DATA_W  = 9,
  localparam int IDX_W  = (N_FLAGS > 1) ? $clog2(N_FLAGS) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              p0_mem_en,
  input  logic              p0_sem_sel,
  input  logic              p0_we,
  input  logic [IDX_W-1:0]  p0_idx,
  input  logic              p0_wbit,
  output logic              p0_rvalid,
  output logic [DATA_W-1:0] p0_rdata,
  input  logic              p1_mem_en,
  input  logic              p1_sem_sel,
  input  logic              p1_we,
  input  logic [IDX_W-1:0]  p1_idx,
  input  logic              p1_wbit,
  output logic              p1_rvalid,
  output logic [DATA_W-1:0] p1_rdata
);
  logic [N_FLAGS-1:0] take0, drop0, take1, drop1;
  logic [N_FLAGS-1:0] held0_v, held1_v, wait_v;
  logic               rd0, rd1;

  sem_port_decode #(.N_FLAGS(N_FLAGS), .IDX_W(IDX_W)) u_dec0 (
    .mem_en(p0_mem_en), .sem_sel(p0_sem_sel), .we(p0_we), .idx(p0_idx),
    .wbit(p0_wbit), .take(take0), .drop(drop0), .rd_en(rd0)
  );
  sem_port_decode #(.N_FLAGS(N_FLAGS), .IDX_W(IDX_W)) u_dec1 (
    .mem_en(p1_mem_en), .sem_sel(p1_sem_sel), .we(p1_we), .idx(p1_idx),
    .wbit(p1_wbit), .take(take1), .drop(drop1), .rd_en(rd1)
  );

  for (genvar g = 0; g < N_FLAGS; g++) begin : g_flag
    sem_req_t q0, q1;
    assign q0 = '{take: take0[g], drop: drop0[g]};
    assign q1 = '{take: take1[g], drop: drop1[g]};
    sem_flag_fsm u_fsm (
      .clk(clk), .rst_n(rst_n), .r0(q0), .r1(q1),
      .held0(held0_v[g]), .held1(held1_v[g]), .waiting(wait_v[g])
    );
  end

  sem_read_port #(.N_FLAGS(N_FLAGS), .IDX_W(IDX_W), .DATA_W(DATA_W)) u_rd0 (
    .clk(clk), .rst_n(rst_n), .rd_en(rd0), .idx(p0_idx), .mine(held0_v),
    .rvalid(p0_rvalid), .rdata(p0_rdata)
  );
  sem_read_port #(.N_FLAGS(N_FLAGS), .IDX_W(IDX_W), .DATA_W(DATA_W)) u_rd1 (
    .clk(clk), .rst_n(rst_n), .rd_en(rd1), .idx(p1_idx), .mine(held1_v),
    .rvalid(p1_rvalid), .rdata(p1_rdata)
  );
endmodule

// File: rtl/sem_bank_chk.sv
module sem_bank_chk #(
  parameter int N_FLAGS = 8,
  parameter int DATA_W  = 9,
  parameter int IDX_W   = 3
) (
  input logic               clk,
  input logic               rst_n,
  input logic               p0_mem_en,
  input logic               p0_sem_sel,
  input logic               p0_we,
  input logic [IDX_W-1:0]   p0_idx,
  input logic               p0_wbit,
  input logic               p0_rvalid,
  input logic [DATA_W-1:0]  p0_rdata,
  input logic               p1_mem_en,
  input logic               p1_sem_sel,
  input logic               p1_we,
  input logic [IDX_W-1:0]   p1_idx,
  input logic               p1_wbit,
  input logic               p1_rvalid,
  input logic [DATA_W-1:0]  p1_rdata,
  input logic [N_FLAGS-1:0] held0_v,
  input logic [N_FLAGS-1:0] held1_v,
  input logic [N_FLAGS-1:0] wait_v
);
  logic acc0, acc1, w0_take, w0_drop, w1_take, w1_drop, same;
  logic [IDX_W-1:0] i0_q, i1_q;

  assign acc0    = p0_sem_sel && !p0_mem_en;
  assign acc1    = p1_sem_sel && !p1_mem_en;
  assign w0_take = acc0 && p0_we && !p0_wbit;
  assign w0_drop = acc0 && p0_we && p0_wbit;
  assign w1_take = acc1 && p1_we && !p1_wbit;
  assign w1_drop = acc1 && p1_we && p1_wbit;
  assign same    = (p0_idx == p1_idx);

  always_ff @(posedge clk) begin
    i0_q <= p0_idx;
    i1_q <= p1_idx;
  end

  AST_FREE_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
    w0_take && !held0_v[p0_idx] && !held1_v[p0_idx] |=> held0_v[i0_q]); // R4
  AST_TIE_LEFT: assert property (@(posedge clk) disable iff (!rst_n)
    w0_take && w1_take && same && !held0_v[p0_idx] && !held1_v[p0_idx]
    |=> held0_v[i0_q] && wait_v[i0_q]); // R9
  AST_NONHOLDER_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    w0_take && held1_v[p0_idx] && !(w1_drop && same)
    |=> held1_v[i0_q] && wait_v[i0_q]); // R5
  AST_HANDOFF: assert property (@(posedge clk) disable iff (!rst_n)
    w0_drop && held0_v[p0_idx] && wait_v[p0_idx] && !(acc1 && p1_we && same)
    |=> held1_v[i0_q]); // R6
  AST_RELEASE_FREE: assert property (@(posedge clk) disable iff (!rst_n)
    w0_drop && held0_v[p0_idx] && !wait_v[p0_idx] && !(w1_take && same)
    |=> !held0_v[i0_q] && !held1_v[i0_q]); // R7
  AST_WITHDRAW: assert property (@(posedge clk) disable iff (!rst_n)
    w1_drop && held0_v[p1_idx] && !(w0_drop && same) |=> !wait_v[i1_q]); // R10
  AST_GATED_P0: assert property (@(posedge clk) disable iff (!rst_n)
    !acc0 |=> !p0_rvalid); // R2
  AST_GATED_P1: assert property (@(posedge clk) disable iff (!rst_n)
    !acc1 |=> !p1_rvalid); // R2
  AST_RESP_P0: assert property (@(posedge clk) disable iff (!rst_n)
    acc0 && !p0_we |=> p0_rvalid && (p0_rdata == {DATA_W{1'b0}}) == $past(held0_v[p0_idx])); // R3
  AST_RESP_P1: assert property (@(posedge clk) disable iff (!rst_n)
    acc1 && !p1_we |=> p1_rvalid && (p1_rdata == {DATA_W{1'b0}}) == $past(held1_v[p1_idx])); // R3
endmodule

bind hw_semaphore_bank sem_bank_chk #(
  .N_FLAGS(N_FLAGS), .DATA_W(DATA_W), .IDX_W(IDX_W)
) u_chk (
  .clk(clk), .rst_n(rst_n),
  .p0_mem_en(p0_mem_en), .p0_sem_sel(p0_sem_sel), .p0_we(p0_we), .p0_idx(p0_idx),
  .p0_wbit(p0_wbit), .p0_rvalid(p0_rvalid), .p0_rdata(p0_rdata),
  .p1_mem_en(p1_mem_en), .p1_sem_sel(p1_sem_sel), .p1_we(p1_we), .p1_idx(p1_idx),
  .p1_wbit(p1_wbit), .p1_rvalid(p1_rvalid), .p1_rdata(p1_rdata),
  .held0_v(held0_v), .held1_v(held1_v), .wait_v(wait_v)
);

// File: tb/sim_hw_semaphore_bank.sv
module sim_hw_semaphore_bank;
  localparam int NF = 8;
  localparam int DW = 9;
  localparam int IW = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic p0_mem_en, p0_sem_sel, p0_we, p0_wbit;
  logic p1_mem_en, p1_sem_sel, p1_we, p1_wbit;
  logic [IW-1:0] p0_idx, p1_idx;
  logic p0_rvalid, p1_rvalid;
  logic [DW-1:0] p0_rdata, p1_rdata;

  int checks = 0;
  int errors = 0;
  bit exp_q0[$];
  bit exp_q1[$];
  string tag_q0[$];
  string tag_q1[$];

  always #5 clk = ~clk;

  hw_semaphore_bank #(.N_FLAGS(NF), .DATA_W(DW)) u0 (
    .clk(clk), .rst_n(rst_n),
    .p0_mem_en(p0_mem_en), .p0_sem_sel(p0_sem_sel), .p0_we(p0_we), .p0_idx(p0_idx),
    .p0_wbit(p0_wbit), .p0_rvalid(p0_rvalid), .p0_rdata(p0_rdata),
    .p1_mem_en(p1_mem_en), .p1_sem_sel(p1_sem_sel), .p1_we(p1_we), .p1_idx(p1_idx),
    .p1_wbit(p1_wbit), .p1_rvalid(p1_rvalid), .p1_rdata(p1_rdata)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic idle();
    p0_mem_en = 1'b1; p0_sem_sel = 1'b0; p0_we = 1'b0; p0_idx = '0; p0_wbit = 1'b0;
    p1_mem_en = 1'b1; p1_sem_sel = 1'b0; p1_we = 1'b0; p1_idx = '0; p1_wbit = 1'b0;
  endtask

  // Port operations for the current cycle
  task automatic wr(input int port, input int idx, input bit b);
    if (port == 0) begin
      p0_mem_en = 1'b0; p0_sem_sel = 1'b1; p0_we = 1'b1; p0_idx = IW'(idx); p0_wbit = b;
    end else begin
      p1_mem_en = 1'b0; p1_sem_sel = 1'b1; p1_we = 1'b1; p1_idx = IW'(idx); p1_wbit = b;
    end
  endtask

  task automatic rd(input int port, input int idx, input bit exp, input string tag);
    if (port == 0) begin
      p0_mem_en = 1'b0; p0_sem_sel = 1'b1; p0_we = 1'b0; p0_idx = IW'(idx);
      exp_q0.push_back(exp); tag_q0.push_back(tag);
    end else begin
      p1_mem_en = 1'b0; p1_sem_sel = 1'b1; p1_we = 1'b0; p1_idx = IW'(idx);
      exp_q1.push_back(exp); tag_q1.push_back(tag);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
    idle();
  endtask

  task automatic rd_both(input int idx, input bit e0, input bit e1, input string tag);
    rd(0, idx, e0, tag); rd(1, idx, e1, tag); tick();
  endtask

  // Monitor: pop expected read responses in order
  always @(negedge clk) begin
    if (rst_n) begin
      if (p0_rvalid) begin
        if (exp_q0.size() == 0) check(1'b0, "R2 unexpected p0 response", 1, 0);
        else begin
          automatic bit e = exp_q0.pop_front();
          automatic string t = tag_q0.pop_front();
          check(p0_rdata == {DW{e}}, t, int'(p0_rdata), int'({DW{e}}));
        end
      end
      if (p1_rvalid) begin
        if (exp_q1.size() == 0) check(1'b0, "R2 unexpected p1 response", 1, 0);
        else begin
          automatic bit e = exp_q1.pop_front();
          automatic string t = tag_q1.pop_front();
          check(p1_rdata == {DW{e}}, t, int'(p1_rdata), int'({DW{e}}));
        end
      end
    end
  end

  initial begin
    #2000000;
    errors++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    idle();
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(!p0_rvalid && !p1_rvalid, "R8 rvalid low in reset", int'(p0_rvalid | p1_rvalid), 0);
    rst_n = 1'b1;
    tick();

    // R8: all flags free after reset
    for (int i = 0; i < NF; i++) rd_both(i, 1'b1, 1'b1, "R8 free after reset");

    // R4 grant, R1 independence, R3 replicated view
    wr(0, 3, 1'b0); tick();
    rd_both(3, 1'b0, 1'b1, "R4 grant to port 0");
    rd_both(2, 1'b1, 1'b1, "R1 neighbour untouched");
    wr(1, 7, 1'b0); tick();
    rd_both(7, 1'b1, 1'b0, "R1 top index held by port 1");
    rd_both(3, 1'b0, 1'b1, "R1 flag 3 unchanged by flag 7");

    // R11: holder rewrites 0, idle release of a free flag
    wr(0, 3, 1'b0); tick();
    rd_both(3, 1'b0, 1'b1, "R11 holder rewrite 0");
    wr(0, 4, 1'b1); tick();
    rd_both(4, 1'b1, 1'b1, "R11 release of free flag");

    // R5 pending request, R6 hand-off
    wr(1, 3, 1'b0); tick();
    rd_both(3, 1'b0, 1'b1, "R5 non-holder request invisible");
    wr(0, 3, 1'b1); tick();
    rd_both(3, 1'b1, 1'b0, "R6 token passes to waiter");
    // R7 release with nothing pending
    wr(1, 3, 1'b1); tick();
    rd_both(3, 1'b1, 1'b1, "R7 release frees flag");
    wr(1, 7, 1'b1); tick();
    rd_both(7, 1'b1, 1'b1, "R7 flag 7 freed");

    // R9 same-cycle tie
    wr(0, 5, 1'b0); wr(1, 5, 1'b0); tick();
    rd_both(5, 1'b0, 1'b1, "R9 port 0 wins tie");
    wr(0, 5, 1'b1); tick();
    rd_both(5, 1'b1, 1'b0, "R9 port 1 request kept pending");
    wr(1, 5, 1'b1); tick();
    rd_both(5, 1'b1, 1'b1, "R7 flag 5 freed");

    // R10 withdraw
    wr(0, 6, 1'b0); tick();
    wr(1, 6, 1'b0); tick();
    wr(1, 6, 1'b1); tick();
    rd_both(6, 1'b0, 1'b1, "R10 withdraw keeps holder");
    wr(0, 6, 1'b1); tick();
    rd_both(6, 1'b1, 1'b1, "R10 free after withdraw");

    // R2 gating: memory enable high, or select low
    wr(0, 1, 1'b0); p0_mem_en = 1'b1; tick();
    rd_both(1, 1'b1, 1'b1, "R2 write with mem enable ignored");
    wr(1, 1, 1'b0); p1_sem_sel = 1'b0; tick();
    rd_both(1, 1'b1, 1'b1, "R2 write without select ignored");
    p0_mem_en = 1'b1; p0_sem_sel = 1'b1; p0_we = 1'b0; p0_idx = 3'd1;
    tick();
    check(!p0_rvalid, "R2 gated read gives no response", int'(p0_rvalid), 0);

    // R3 response lasts one cycle, pre-write view
    rd(0, 2, 1'b1, "R3 view before same-cycle write"); wr(1, 2, 1'b0); tick();
    tick();
    check(!p0_rvalid, "R3 rvalid single cycle", int'(p0_rvalid), 0);
    rd_both(2, 1'b1, 1'b0, "R4 grant to port 1");

    repeat (3) tick();
    check(exp_q0.size() == 0 && exp_q1.size() == 0, "R3 all reads answered",
          exp_q0.size() + exp_q1.size(), 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule